// File: doc/BRIEF.md
# Stepper microstepping indexer

This block holds the electrical position of a two-phase stepper motor and turns it into signed current setpoints for the two coils. Each active step event moves the position one step of the selected resolution, forward or backward. The resolution ranges from full step down to 1/256 step. Coil A follows the sine of the electrical angle and coil B follows the cosine, on a signed scale of -255 to +255. A positive value means current flows from the coil's first output to its second.

Step and direction each come from a pin or from a register bit, chosen separately. A register step request gives exactly one step. The step pin can be made to count both of its edges. A soft index reset returns the position to the 45° home state and leaves the configuration untouched. If the step mode is changed during motion, the next step lands on the nearest position that is valid for the new mode.

Top module: `stepIndexer`

## Requirements
- R1: After the asynchronous reset (rstN low), position is 128 (45°) and atHome is 1. In mode 0001, coilA and coilB are both 180 (71 % of 255).
- R2: The position index has 1024 states per electrical cycle. The step size in index units is set by stepMode:
  - 0000 and 0001: 256.
  - 0010 and 0011: 128.
  - 0100: 64.
  - 0101: 32.
  - 0110: 16.
  - 0111: 8.
  - 1000: 4.
  - 1001: 2.
  - 1010: 1.
- R3: When the effective direction is 1, a step increases the position; when it is 0, a step decreases it. The index wraps modulo 1024.
- R4: With stepRegSel=1, each rising edge of stepReq gives exactly one step, and stepPin is ignored. With stepRegSel=0, stepReq is ignored. The effective direction is dirReg when dirRegSel=1 and dirPin when dirRegSel=0.
- R5: With regIface=1 and bothEdges=1, both edges of stepPin are active. In every other case only the rising edge is active. A position update appears one clock after the edge is sampled.
- R6: idxReset high sets the position to 128 on the next clock, with priority over stepping. The step mode in force afterwards is unchanged.
- R7: A step always lands on the nearest position that is valid for the current mode and lies strictly ahead in the direction of motion. For the full-step modes (0000, 0001) the valid positions are 128 + 256k. For all other modes they are the multiples of the step size.
- R8: coilA is round(255·sin(2π·position/1024)) within ±1, and coilB is the same with cos in place of sin. Both carry the sign of the function.
- R9: In mode 0000 both coils are ±255 at every valid position. In mode 0010, diagonal positions (position mod 256 = 128) drive both coils to ±255, and on-axis positions drive one coil to ±255 and the other to 0.
- R10: atHome is 1 exactly when position equals 128.
- R11: The unused codes 1011 to 1111 step like code 1010 (step size 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepMode | input | 4 | Step resolution code |
| stepPin | input | 1 | Synchronized step input |
| dirPin | input | 1 | Direction input pin |
| stepRegSel | input | 1 | 1: step from stepReq, 0: from stepPin |
| dirRegSel | input | 1 | 1: direction from dirReg, 0: from dirPin |
| dirReg | input | 1 | Register direction bit |
| stepReq | input | 1 | Register step request, one step per rising edge |
| bothEdges | input | 1 | Count both stepPin edges (register interface only) |
| regIface | input | 1 | 1: register interface, 0: pin interface |
| idxReset | input | 1 | Soft return to the home position |
| position | output | 10 | Electrical position, 1/256 step per LSB |
| coilA | output | 9 | Signed coil A setpoint (sine) |
| coilB | output | 9 | Signed coil B setpoint (cosine) |
| atHome | output | 1 | Position equals 128 |

## Verification
The hardest case to reach is a mode change in the middle of motion. Here the position sits off the new mode's grid, and the snap must go strictly forward or backward and still wrap correctly across index 0. The vector table gets there by fine steps that leave the position at odd values such as 543 and 584. It then switches to a coarse mode in either direction and steps once. This is followed by a run of 100 % full steps that crosses 1023/0 both ways.

// File: rtl/stepIdxPkg.sv
package stepIdxPkg;

  typedef struct packed {
    logic advance;
    logic forward;
    logic home;
  } idxStrobeT;

  // log2 of the step size in index units for a mode code
  function automatic int modeShift(input logic [3:0] mode, input int posW);
    int s;
    if (mode <= 4'd1)      s = posW - 2;
    else if (mode <= 4'd3) s = posW - 3;
    else if (mode <= 4'd10) s = posW - int'(mode);
    else                    s = 0;
    if (s < 0) s = 0;
    return s;
  endfunction

  // rational quarter-wave sine approximation, rounded to the amplitude scale
  function automatic int sineAt(input int t, input int quarter, input int ampMax);
    longint u, den;
    u   = longint'(t) * longint'(2 * quarter - t);
    den = 5 * longint'(quarter) * longint'(quarter) - u;
    return int'((8 * longint'(ampMax) * u + den) / (2 * den));
  endfunction

endpackage

// File: rtl/stepIdxCtrl.sv
module stepIdxCtrl
  import stepIdxPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stepPin,
  input  logic      dirPin,
  input  logic      stepRegSel,
  input  logic      dirRegSel,
  input  logic      dirReg,
  input  logic      stepReq,
  input  logic      bothEdges,
  input  logic      regIface,
  input  logic      idxReset,
  output idxStrobeT strobe
);

  logic pinPrev;
  logic reqPrev;
  logic pinRise;
  logic pinFall;
  logic reqRise;
  logic pinActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev <= 1'b0;
      reqPrev <= 1'b0;
    end else begin
      pinPrev <= stepPin;
      reqPrev <= stepReq;
    end
  end

  always_comb begin
    pinRise   = stepPin & ~pinPrev;
    pinFall   = ~stepPin & pinPrev;
    reqRise   = stepReq & ~reqPrev;
    pinActive = pinRise | (pinFall & bothEdges & regIface);
    strobe.home    = idxReset;
    strobe.forward = dirRegSel ? dirReg : dirPin;
    strobe.advance = stepRegSel ? reqRise : pinActive;
  end

endmodule

// File: rtl/stepIdxCoil.sv
module stepIdxCoil
  import stepIdxPkg::*;
#(
  parameter int POS_W = 10,
  parameter int AMP_W = 8
) (
  input  logic [POS_W-1:0]        phase,
  input  logic                    fullPower,
  output logic signed [AMP_W:0]   drive
);

  localparam int QUARTER = 1 << (POS_W - 2);
  localparam int AMP_MAX = (1 << AMP_W) - 1;
  localparam int OFF_W   = POS_W - 2;

  logic [AMP_W-1:0] sineTab [0:QUARTER];

  for (genvar g = 0; g <= QUARTER; g++) begin : g_tab
    assign sineTab[g] = AMP_W'(sineAt(g, QUARTER, AMP_MAX));
  end

  logic [1:0]       quad;
  logic [OFF_W-1:0] offs;
  logic [OFF_W:0]   tabIdx;
  logic [AMP_W-1:0] mag;
  logic             diag;

  always_comb begin
    quad   = phase[POS_W-1 -: 2];
    offs   = phase[OFF_W-1:0];
    tabIdx = quad[0] ? ((OFF_W+1)'(QUARTER) - {1'b0, offs}) : {1'b0, offs};
    diag   = (offs == OFF_W'(QUARTER / 2));
    mag    = (fullPower && diag) ? AMP_W'(AMP_MAX) : sineTab[tabIdx];
    drive  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

endmodule

// File: rtl/stepIdxDatapath.sv
module stepIdxDatapath
  import stepIdxPkg::*;
#(
  parameter int POS_W = 10,
  parameter int AMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [3:0]            stepMode,
  input  idxStrobeT             strobe,
  output logic [POS_W-1:0]      position,
  output logic signed [AMP_W:0] coilA,
  output logic signed [AMP_W:0] coilB,
  output logic                  atHome
);

  localparam int QUARTER = 1 << (POS_W - 2);
  localparam logic [POS_W-1:0] HOME = POS_W'(QUARTER / 2);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] stepSize;
  logic [POS_W-1:0] mask;
  logic [POS_W-1:0] offset;
  logic [POS_W-1:0] rel;
  logic [POS_W-1:0] fwdNext;
  logic [POS_W-1:0] revNext;
  logic             fullPower;

  always_comb begin
    stepSize = POS_W'(1) << modeShift(stepMode, POS_W);
    mask     = ~(stepSize - POS_W'(1));
    offset   = (stepMode <= 4'd1) ? HOME : '0;
    rel      = pos - offset;
    fwdNext  = (rel & mask) + stepSize + offset;
    revNext  = ((rel + stepSize - POS_W'(1)) & mask) - stepSize + offset;
    fullPower = (stepMode == 4'd0) || (stepMode == 4'd2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pos <= HOME;
    else if (strobe.home)    pos <= HOME;
    else if (strobe.advance) pos <= strobe.forward ? fwdNext : revNext;
  end

  stepIdxCoil #(.POS_W(POS_W), .AMP_W(AMP_W)) i_coilA (
    .phase(pos), .fullPower(fullPower), .drive(coilA)
  );

  stepIdxCoil #(.POS_W(POS_W), .AMP_W(AMP_W)) i_coilB (
    .phase(pos + POS_W'(QUARTER)), .fullPower(fullPower), .drive(coilB)
  );

  assign position = pos;
  assign atHome   = (pos == HOME);

endmodule

// File: rtl/stepIndexer.sv
module stepIndexer
  import stepIdxPkg::*;
#(
  parameter int POS_W = 10,
  parameter int AMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [3:0]            stepMode,
  input  logic                  stepPin,
  input  logic                  dirPin,
  input  logic                  stepRegSel,
  input  logic                  dirRegSel,
  input  logic                  dirReg,
  input  logic                  stepReq,
  input  logic                  bothEdges,
  input  logic                  regIface,
  input  logic                  idxReset,
  output logic [POS_W-1:0]      position,
  output logic signed [AMP_W:0] coilA,
  output logic signed [AMP_W:0] coilB,
  output logic                  atHome
);

  idxStrobeT strobe;

  stepIdxCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .stepPin(stepPin), .dirPin(dirPin),
    .stepRegSel(stepRegSel), .dirRegSel(dirRegSel), .dirReg(dirReg),
    .stepReq(stepReq), .bothEdges(bothEdges), .regIface(regIface),
    .idxReset(idxReset), .strobe(strobe)
  );

  stepIdxDatapath #(.POS_W(POS_W), .AMP_W(AMP_W)) i_dp (
    .clk(clk), .rstN(rstN), .stepMode(stepMode), .strobe(strobe),
    .position(position), .coilA(coilA), .coilB(coilB), .atHome(atHome)
  );

endmodule

// File: rtl/stepIndexer_chk.sv
module stepIndexer_chk #(
  parameter int POS_W = 10,
  parameter int AMP_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [3:0]            stepMode,
  input logic                  stepPin,
  input logic                  stepRegSel,
  input logic                  idxReset,
  input logic [POS_W-1:0]      position,
  input logic signed [AMP_W:0] coilA,
  input logic signed [AMP_W:0] coilB,
  input logic                  atHome
);

  localparam int HALF = 1 << (POS_W - 1);
  localparam logic [POS_W-1:0] HOME = POS_W'(1 << (POS_W - 3));

  // R6
  soft_home_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxReset |=> position == HOME);

  // R5
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !stepRegSel && !idxReset && stepPin == $past(stepPin))
    |=> position == $past(position));

  // R7
  full_grid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(stepMode) <= 4'd1 && position != $past(position))
    |-> position[POS_W-3:0] == HOME[POS_W-3:0]);

  // R8
  sine_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(position) < HALF) |-> coilA >= 0);

  // R10
  home_coil_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atHome && stepMode == 4'd1) |-> (coilA == coilB && coilA > 0));

endmodule

bind stepIndexer stepIndexer_chk #(.POS_W(POS_W), .AMP_W(AMP_W)) i_chk (
  .clk(clk), .rstN(rstN), .stepMode(stepMode), .stepPin(stepPin),
  .stepRegSel(stepRegSel), .idxReset(idxReset), .position(position),
  .coilA(coilA), .coilB(coilB), .atHome(atHome)
);

// File: tb/test_stepIndexer.sv
module test_stepIndexer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] stepMode = 4'd1;
  logic stepPin = 0, dirPin = 1, stepRegSel = 0, dirRegSel = 0, dirReg = 0;
  logic stepReq = 0, bothEdges = 0, regIface = 0, idxReset = 0;
  logic [9:0] position;
  logic signed [8:0] coilA, coilB;
  logic atHome;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stepIndexer i_stepIndexer (
    .clk(clk), .rstN(rstN), .stepMode(stepMode), .stepPin(stepPin),
    .dirPin(dirPin), .stepRegSel(stepRegSel), .dirRegSel(dirRegSel),
    .dirReg(dirReg), .stepReq(stepReq), .bothEdges(bothEdges),
    .regIface(regIface), .idxReset(idxReset), .position(position),
    .coilA(coilA), .coilB(coilB), .atHome(atHome)
  );

  typedef struct packed {
    logic [3:0] mode;
    logic       dir;
    logic [9:0] expPos;
  } vecT;

  localparam int NV = 19;
  localparam vecT VEC [0:NV-1] = '{
    '{4'd1,  1'b1, 10'd384}, '{4'd1,  1'b1, 10'd640}, '{4'd1,  1'b0, 10'd384},
    '{4'd3,  1'b1, 10'd512}, '{4'd5,  1'b1, 10'd544}, '{4'd10, 1'b0, 10'd543},
    '{4'd1,  1'b1, 10'd640}, '{4'd4,  1'b0, 10'd576}, '{4'd7,  1'b1, 10'd584},
    '{4'd1,  1'b0, 10'd384}, '{4'd11, 1'b1, 10'd385}, '{4'd2,  1'b1, 10'd512},
    '{4'd0,  1'b1, 10'd640}, '{4'd0,  1'b1, 10'd896}, '{4'd0,  1'b1, 10'd128},
    '{4'd0,  1'b0, 10'd896}, '{4'd6,  1'b1, 10'd912}, '{4'd9,  1'b0, 10'd910},
    '{4'd8,  1'b1, 10'd912}
  };

  function automatic int expCoil(input int pos, input int mode, input bit isB);
    int p;
    real ang;
    p = (isB ? pos + 256 : pos) % 1024;
    if ((mode == 0 || mode == 2) && (p % 256) == 128) return (p < 512) ? 255 : -255;
    ang = 2.0 * 3.14159265358979 * real'(p) / 1024.0;
    return $rtoi(255.0 * $sin(ang) + ((ang < 3.14159265358979) ? 0.5 : -0.5));
  endfunction

  task automatic check(input string tag, input int act, input int exp, input int tol);
    nVec++;
    if (act > exp + tol || act < exp - tol) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input int expPos, input int mode);
    check({tag, " position"}, int'(position), expPos, 0);
    check({tag, " coilA"}, int'(coilA), expCoil(expPos, mode, 1'b0), 1);
    check({tag, " coilB"}, int'(coilB), expCoil(expPos, mode, 1'b1), 1);
    check({tag, " atHome R10"}, int'(atHome), int'(expPos == 128), 0);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulsePin();
    @(negedge clk) stepPin = 1'b1;
    @(negedge clk) stepPin = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    cyc(3);
    // R1 reset state
    checkAll("R1 reset", 128, 1);
    @(negedge clk) rstN = 1'b1;
    cyc(1);
    checkAll("R1 after release", 128, 1);

    // R2 R3 R7 R9 R11 vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      stepMode = VEC[i].mode;
      dirPin   = VEC[i].dir;
      pulsePin();
      checkAll($sformatf("R2/R3/R7/R9/R11 vec%0d", i), int'(VEC[i].expPos), int'(VEC[i].mode));
    end

    // R5 both edges in register interface, 1/256 mode, forward
    stepMode = 4'd10; dirPin = 1'b1; regIface = 1'b1; bothEdges = 1'b1;
    @(negedge clk) stepPin = 1'b1;
    @(negedge clk);
    check("R5 rise", int'(position), 913, 0);
    stepPin = 1'b0;
    @(negedge clk);
    check("R5 fall counted", int'(position), 914, 0);
    // R5 pin interface ignores the falling edge
    regIface = 1'b0;
    @(negedge clk) stepPin = 1'b1;
    @(negedge clk) stepPin = 1'b0;
    @(negedge clk);
    check("R5 fall ignored", int'(position), 915, 0);
    bothEdges = 1'b0;

    // R4 register step request held high gives one step, pin ignored
    stepRegSel = 1'b1;
    @(negedge clk) stepReq = 1'b1;
    cyc(3);
    check("R4 held request", int'(position), 916, 0);
    stepReq = 1'b0;
    pulsePin();
    check("R4 pin ignored", int'(position), 916, 0);
    // R4 register direction overrides pin
    dirRegSel = 1'b1; dirReg = 1'b0;
    @(negedge clk) stepReq = 1'b1;
    @(negedge clk) stepReq = 1'b0;
    @(negedge clk);
    check("R4 dirReg reverse", int'(position), 915, 0);
    // R4 request ignored in pin step mode
    stepRegSel = 1'b0;
    @(negedge clk) stepReq = 1'b1;
    @(negedge clk) stepReq = 1'b0;
    @(negedge clk);
    check("R4 request ignored", int'(position), 915, 0);
    dirRegSel = 1'b0;

    // R6 soft reset, then mode still in effect (1/8, forward)
    stepMode = 4'd5;
    @(negedge clk) idxReset = 1'b1;
    @(negedge clk) idxReset = 1'b0;
    checkAll("R6 soft reset", 128, 5);
    pulsePin();
    check("R6 mode kept", int'(position), 160, 0);
    // R6 soft reset wins over a simultaneous step
    @(negedge clk) begin idxReset = 1'b1; stepPin = 1'b1; end
    @(negedge clk) begin idxReset = 1'b0; stepPin = 1'b0; end
    check("R6 priority", int'(position), 128, 0);

    // R1 hard reset mid-motion
    pulsePin();
    @(negedge clk) rstN = 1'b0;
    stepMode = 4'd1;
    @(negedge clk);
    checkAll("R1 hard reset", 128, 1);
    rstN = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule